// File: doc/BRIEF.md
# Two-Grid Fluorescent Display Drive Timer

This block generates the multiplexed drive waveforms for a vacuum fluorescent display that has two grids sharing 17 segment lines. A divide-by-four prescaler turns the system clock into a bit-time tick. A frame lasts 4096 bit times and is split into two halves of 2048 bit times each. Grid 1 owns the first half and grid 2 owns the second. In each half the segment lines carry the 17 display-latch bits that belong to that grid. Both grids are blank for a guard interval at the start of every half.

The mode input picks one of two brightness settings. Day mode drives each grid for 2032 of its 2048 bit times. Dark mode drives each grid for a duty count N out of 2048 that comes from outside, and N is capped at 256. The segments come on 6 bit times before the grid does and go off together with it. The mode and the duty count are captured only when a new frame starts. A frame therefore never holds a partial pulse, and a change made in the middle of a frame first shows in the following frame.

Top module: `vfd_duplex_timer`

## Requirements
- R1: One bit time is 4 clock cycles. Every grid edge falls on a bit-time boundary, so a grid is active for exactly 4 clocks per active bit time.
- R2: A frame is 4096 bit times long. Bit times 0 to 2047 form the grid 1 half, in which only grid_n_o[0] may go low. Bit times 2048 to 4095 form the grid 2 half, in which only grid_n_o[1] may go low.
- R3: Within the segment window, seg_o equals latch_i[16:0] during the grid 1 half and latch_i[33:17] during the grid 2 half. Outside the window seg_o is all zeros.
- R4: In day mode (dark_i=0), a grid is active from position 16 to position 2047 of its half. Position is the bit time counted from the start of the half. This gives 2032 active bit times and 16 blank bit times before each grid.
- R5: In day mode the segment window covers positions 10 to 2047, which is 2038 bit times, starting 6 bit times before the grid. seg_o is zero at positions 0 to 9.
- R6: In dark mode (dark_i=1) with duty count N, a grid is active at positions 16 to 15+N and the segment window covers positions 10 to 15+N. A duty_i value above 256 is treated as 256.
- R7: A captured duty count of 0 in dark mode keeps both grids inactive and seg_o at zero for the whole frame.
- R8: The grid outputs are active low. The two grids are never active at the same time.
- R9: dark_i and duty_i are captured only at the start of a frame. A change in the middle of a frame has no effect until the next frame. The frame that follows reset behaves as dark mode with N=0.
- R10: While reset is asserted, seg_o is all zeros and grid_n_o is 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 4 cycles per bit time |
| rst_n | input | 1 | Asynchronous reset, active low |
| dark_i | input | 1 | Mode select: 1 for dark mode, 0 for day mode |
| duty_i | input | 9 | Dark-mode on-time in bit times out of 2048; values above 256 are capped |
| latch_i | input | 34 | Display data; [16:0] for grid 1, [33:17] for grid 2 |
| seg_o | output | 17 | Segment drive, active high |
| grid_n_o | output | 2 | Grid pre-driver outputs, active low; [0] for grid 1, [1] for grid 2 |

## Verification
The grid outputs are decoded straight from the prescaler, position and configuration registers. They therefore change in the clock cycle that follows the edge which moves the counters, and the bench model, stepped on the same rising edge, predicts them with no extra delay. The segment lines also pass the current latch input through without a register, so the bench compares both outputs at the falling edge and changes its inputs only after that comparison. A mode or duty change is due one full frame boundary later: at most 16384 clocks after the change is applied. It is checked by counting the active grid cycles in each completed frame against the configuration that was captured at that frame's start.

// File: rtl/vfd_duplex_timer.sv
module vfd_duplex_timer #(
  parameter int PRESCALE  = 4,
  parameter int HALF_BITS = 2048,
  parameter int SEGS      = 17,
  parameter int GUARD     = 16,
  parameter int SEG_LEAD  = 6,
  parameter int DUTY_W    = 9,
  parameter int DUTY_MAX  = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dark_i,
  input  logic [DUTY_W-1:0]   duty_i,
  input  logic [2*SEGS-1:0]   latch_i,
  output logic [SEGS-1:0]     seg_o,
  output logic [1:0]          grid_n_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int HW = $clog2(HALF_BITS);
  localparam logic [PW-1:0]     PRE_LAST  = PW'(PRESCALE - 1);
  localparam logic [HW-1:0]     POS_LAST  = HW'(HALF_BITS - 1);
  localparam logic [HW:0]       GUARD_L   = (HW+1)'(GUARD);
  localparam logic [HW:0]       SEG_ST_L  = (HW+1)'(GUARD - SEG_LEAD);
  localparam logic [HW:0]       DAY_ON_L  = (HW+1)'(HALF_BITS - GUARD);
  localparam logic [DUTY_W-1:0] DUTY_CAP  = DUTY_W'(DUTY_MAX);

  logic [PW-1:0]     pre_q;
  logic [HW-1:0]     pos_q;
  logic              half_q;
  logic              dark_q;
  logic [DUTY_W-1:0] duty_q;

  logic              tick, half_end, frame_end;
  logic [DUTY_W-1:0] duty_c;
  logic [HW:0]       pos_x, on_len, win_end;
  logic              grid_win, seg_win;

  assign tick      = (pre_q == PRE_LAST);
  assign half_end  = tick && (pos_q == POS_LAST);
  assign frame_end = half_end && half_q;
  assign duty_c    = (duty_i > DUTY_CAP) ? DUTY_CAP : duty_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      pos_q  <= '0;
      half_q <= 1'b0;
      dark_q <= 1'b1;
      duty_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) pos_q <= half_end ? '0 : pos_q + 1'b1;
      if (half_end) half_q <= ~half_q;
      if (frame_end) begin
        dark_q <= dark_i;
        duty_q <= duty_c;
      end
    end
  end

  assign pos_x    = {1'b0, pos_q};
  assign on_len   = dark_q ? (HW+1)'(duty_q) : DAY_ON_L;
  assign win_end  = GUARD_L + on_len;
  assign grid_win = (on_len != '0) && (pos_x >= GUARD_L)  && (pos_x < win_end);
  assign seg_win  = (on_len != '0) && (pos_x >= SEG_ST_L) && (pos_x < win_end);

  assign seg_o    = seg_win ? (half_q ? latch_i[2*SEGS-1:SEGS] : latch_i[SEGS-1:0]) : '0;
  assign grid_n_o = ~({half_q, ~half_q} & {2{grid_win}});
endmodule

// File: rtl/vfd_duplex_timer_chk.sv
module vfd_duplex_timer_chk #(
  parameter int PRESCALE  = 4,
  parameter int HALF_BITS = 2048,
  parameter int SEGS      = 17,
  parameter int GUARD     = 16,
  parameter int SEG_LEAD  = 6,
  parameter int DUTY_W    = 9,
  parameter int DUTY_MAX  = 256
) (
  input logic                clk,
  input logic                rst_n,
  input logic [((PRESCALE > 1) ? $clog2(PRESCALE) : 1)-1:0] pre_q,
  input logic [$clog2(HALF_BITS)-1:0] pos_q,
  input logic                half_q,
  input logic                dark_q,
  input logic [DUTY_W-1:0]   duty_q,
  input logic [SEGS-1:0]     seg_o,
  input logic [1:0]          grid_n_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int HW = $clog2(HALF_BITS);

  p_grid_on_bit_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(grid_n_o) |-> (pre_q == '0));

  p_grid1_half_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !half_q |-> grid_n_o[1]);

  p_grid2_half_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    half_q |-> grid_n_o[0]);

  p_seg_blank_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pos_q} < (HW+1)'(GUARD - SEG_LEAD)) |-> (seg_o == '0));

  p_dark_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dark_q && ({1'b0, pos_q} >= (HW+1)'(GUARD + DUTY_MAX))) |-> (grid_n_o == 2'b11));

  p_zero_duty_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dark_q && duty_q == '0) |-> (grid_n_o == 2'b11 && seg_o == '0));

  p_grids_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grid_n_o != 2'b00);

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_q == PW'(PRESCALE - 1) && pos_q == HW'(HALF_BITS - 1) && half_q)
      |=> $stable({dark_q, duty_q}));

  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_outputs_r10: assert (seg_o == '0 && grid_n_o == 2'b11);
    end
  end
endmodule

bind vfd_duplex_timer vfd_duplex_timer_chk #(
  .PRESCALE(PRESCALE), .HALF_BITS(HALF_BITS), .SEGS(SEGS), .GUARD(GUARD),
  .SEG_LEAD(SEG_LEAD), .DUTY_W(DUTY_W), .DUTY_MAX(DUTY_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pre_q(pre_q), .pos_q(pos_q), .half_q(half_q),
  .dark_q(dark_q), .duty_q(duty_q), .seg_o(seg_o), .grid_n_o(grid_n_o)
);

// File: tb/vfd_duplex_timer_test.sv
`timescale 1ns/1ps
module vfd_duplex_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dark_i = 1'b0;
  logic [8:0]  duty_i = '0;
  logic [33:0] latch_i = '0;
  logic [16:0] seg_o;
  logic [1:0]  grid_n_o;

  vfd_duplex_timer uut (
    .clk(clk), .rst_n(rst_n), .dark_i(dark_i), .duty_i(duty_i),
    .latch_i(latch_i), .seg_o(seg_o), .grid_n_o(grid_n_o)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, frames = 0;
  int m_pre = 0, m_pos = 0, m_half = 0, m_dark = 1, m_duty = 0;
  int g1_cnt = 0, g2_cnt = 0;
  bit done = 0;

  function automatic int on_len();
    return m_dark ? m_duty : 2032;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (m_pre == 3) begin
        m_pre = 0;
        if (m_pos == 2047) begin
          m_pos = 0;
          if (m_half == 1) begin
            checks += 2;
            if (g1_cnt != 4 * on_len()) begin
              fails++;
              $display("FAIL R1 R2 R9 grid1 active clocks in frame %0d: got %0d expected %0d", frames, g1_cnt, 4 * on_len());
            end
            if (g2_cnt != 4 * on_len()) begin
              fails++;
              $display("FAIL R1 R2 R9 grid2 active clocks in frame %0d: got %0d expected %0d", frames, g2_cnt, 4 * on_len());
            end
            g1_cnt = 0;
            g2_cnt = 0;
            m_dark = dark_i;
            m_duty = (duty_i > 256) ? 256 : int'(duty_i);
            frames++;
          end
          m_half = 1 - m_half;
        end else m_pos++;
      end else m_pre++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int n;
      bit gw, sw;
      logic [1:0]  eg;
      logic [16:0] es;
      string gtag, stag;
      n  = on_len();
      gw = (n > 0) && (m_pos >= 16) && (m_pos < 16 + n);
      sw = (n > 0) && (m_pos >= 10) && (m_pos < 16 + n);
      eg = 2'b11;
      if (gw) eg[m_half] = 1'b0;
      es = sw ? (m_half ? latch_i[33:17] : latch_i[16:0]) : 17'h0;
      gtag = (n == 0) ? "R7" : (m_dark ? "R6" : "R4");
      stag = sw ? "R3" : ((n == 0) ? "R7" : (m_dark ? "R6" : "R5"));
      checks += 3;
      if (grid_n_o != eg) begin
        fails++;
        $display("FAIL %s grid_n_o at half %0d pos %0d: got %b expected %b", gtag, m_half, m_pos, grid_n_o, eg);
      end
      if (seg_o != es) begin
        fails++;
        $display("FAIL %s seg_o at half %0d pos %0d: got %h expected %h", stag, m_half, m_pos, seg_o, es);
      end
      if (grid_n_o == 2'b00) begin
        fails++;
        $display("FAIL R8 both grids active: got %b expected not 00", grid_n_o);
      end
      if (grid_n_o[0] == 1'b0) g1_cnt++;
      if (grid_n_o[1] == 1'b0) g2_cnt++;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    wait (cycles > 190000);
    checks++;
    fails++;
    $display("FAIL watchdog expired: got %0d cycles expected under 190000", cycles);
    finish_run();
  end

  task automatic mid_frame_set(input bit d, input int duty, input logic [33:0] lat);
    int f0;
    f0 = frames;
    repeat (8000) @(negedge clk);
    #1;
    dark_i  = d;
    duty_i  = 9'(duty);
    latch_i = lat;
    wait (frames == f0 + 1);
  endtask

  initial begin
    latch_i = 34'h2_A5C3_9E17;
    duty_i  = 9'd0;
    dark_i  = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (seg_o != 17'h0 || grid_n_o != 2'b11) begin
      fails++;
      $display("FAIL R10 reset outputs: got seg %h grid %b expected seg 00000 grid 11", seg_o, grid_n_o);
    end
    #1 rst_n = 1'b1;
    // R9: first frame blank regardless of day setting applied now
    wait (frames == 1);
    mid_frame_set(1'b1, 100, 34'h1_FFFF_0001);   // R6 next frame
    mid_frame_set(1'b1, 0,   34'h3_FFFF_FFFF);   // R7 next frame
    mid_frame_set(1'b1, 300, 34'h0_1234_5678);   // R6 clamp to 256
    mid_frame_set(1'b1, 256, 34'h2_0000_FFFF);
    mid_frame_set(1'b1, 1,   34'h1_5555_AAAA);
    mid_frame_set(1'b0, 0,   34'h0_F0F0_0F0F);   // R4 R5 day again
    mid_frame_set(1'b0, 0,   34'h3_3333_CCCC);
    @(negedge clk);
    finish_run();
  end
endmodule